// File: doc/BRIEF.md
# Reed-Solomon Syndrome Generator over GF(4096)

This block takes a flash page as a stream of bytes, for example 2048 data bytes followed by 14 check bytes. It regroups the stream into 12-bit symbols and, as each symbol completes, updates eight syndrome accumulators of a Reed-Solomon code over GF(2^12). When the frame ends, the block presents the eight syndromes packed two to a 32-bit word. It also raises a flag when any syndrome is nonzero, which tells the host that the page holds errors. Locating and correcting those errors is left to software or to a later stage.

The field is built as a tower. GF(64) uses the polynomial x^6+x+1. GF(4096) is a quadratic extension of GF(64), and each 12-bit element holds a high half and a low half of six bits each. A frame opens with a byte that carries both start and valid, and it closes with a byte that carries last. Results stay on the outputs until the next frame starts.

Top module: `rs_syndrome_gen`

## Requirements
- R1: Multiplication in GF(64) is shift-and-add modulo x^6+x+1: whenever bit 6 appears, it is cleared by XOR with 0x43. For 12-bit operands split into a high half h (bits 11:6) and a low half l (bits 5:0), the product has high half (ah^al)(bh^bl) ^ al·bl and low half (ah·bh)·0x21 ^ al·bl.
- R2: Symbols are packed MSB-first from a bit stream. The stream is four zero bits followed by the bytes in arrival order. So symbol 0 is {4'h0, byte0}, the next symbol is {byte1, byte2[7:4]}, the one after is {byte2[3:0], byte3}, and this three-byte pattern repeats.
- R3: A final symbol that the frame fills only in part is padded with zeros in its low bits and still enters the syndromes. A 2062-byte frame therefore yields 1375 symbols.
- R4: Syndrome j, for j = 0..7, equals the sum over symbols i of sym_i·(α^j)^(N-1-i), where N is the symbol count and α is the field value 0xE01. This equals Horner's rule S_j ← S_j·α^j ^ sym, started from zero.
- R5: Word k of `synWords`, at bits [32k+31:32k], carries syndrome 2k in bits 11:0 and syndrome 2k+1 in bits 27:16. All other bits are zero.
- R6: `errFlag` is 1 exactly when `resValid` is 1 and at least one syndrome is nonzero.
- R7: `resValid` rises at the clock edge after the edge that absorbs the final symbol. When the last byte is accepted as byte index 3m+2, one extra cycle is needed to absorb the trailing nibble symbol.
- R8: A byte that carries start and valid begins a new frame. It clears `resValid` and `errFlag` at that edge and abandons any frame that is still in progress.
- R9: While no frame is open, bytes that carry valid but not start are ignored, and the syndrome and flag outputs hold their values.
- R10: After reset, `resValid` and `errFlag` are 0 and `synWords` is all zero.
- R11: After a byte with last, a new start must wait at least two idle cycles. Frames are one byte or longer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A byte is present on inByte this cycle |
| inStart | input | 1 | The byte is the first of a frame (qualified by inValid) |
| inLast | input | 1 | The byte is the last of a frame (qualified by inValid) |
| inByte | input | 8 | Stream byte |
| synWords | output | NUM_SYN*16 | Syndromes packed two per 32-bit word |
| errFlag | output | 1 | Some syndrome is nonzero (valid with resValid) |
| resValid | output | 1 | Syndromes and flag describe the last completed frame |

## Verification
A wrong packing phase or held nibble corrupts every syndrome of the frame at once. It shows up at the result edge of that frame, and frames ending in each of the three byte phases expose it. A wrong root constant or multiplier term in one lane corrupts only the matching 12-bit field, so a comparison field by field shows which lane is bad. A control state that wrongly absorbs or drops a symbol shows either as a `resValid` edge one cycle early or late, or as syndromes that change while results should hold.

// File: rtl/rs_syn_pkg.sv
package rs_syn_pkg;

  localparam int HALF_W = 6;
  localparam int SYM_W = 2 * HALF_W;
  localparam int BYTE_W = 8;
  localparam int NIB_W = 4;
  localparam logic [HALF_W:0] HALF_POLY = 7'h43;    // x^6 + x + 1
  localparam logic [HALF_W-1:0] EXT_CONST = 6'h21;  // inverse of the GF(64) generator
  localparam logic [SYM_W-1:0] PRIM_ELEM = 12'hE01;

  typedef enum logic [2:0] {
    SEL_HEAD,      // {0000, byte}
    SEL_SPLIT,     // {held byte, byte[7:4]}
    SEL_JOIN,      // {held nibble, byte}
    SEL_TAIL_BYTE, // {byte, 0000}
    SEL_TAIL_NIB   // {held nibble, 00000000}
  } symSel_e;

  typedef struct packed {
    logic absorb;
    logic clearAcc;
    symSel_e sel;
    logic holdByte;
    logic holdNib;
    logic finish;
  } ctrlStrobe_t;

  function automatic logic [HALF_W-1:0] gf64Mul(input logic [HALF_W-1:0] a,
                                                input logic [HALF_W-1:0] b);
    logic [HALF_W:0] shifted;
    logic [HALF_W-1:0] multiplier;
    logic [HALF_W-1:0] acc;
    acc = '0;
    multiplier = a;
    shifted = {1'b0, b};
    for (int i = 0; i < HALF_W; i++) begin
      if (multiplier[0]) acc = acc ^ shifted[HALF_W-1:0];
      multiplier = multiplier >> 1;
      shifted = shifted << 1;
      if (shifted[HALF_W]) shifted = shifted ^ HALF_POLY;
    end
    return acc;
  endfunction

  function automatic logic [SYM_W-1:0] gf4096Mul(input logic [SYM_W-1:0] a,
                                                 input logic [SYM_W-1:0] b);
    logic [HALF_W-1:0] ah, al, bh, bl, lowProd, hiOut, loOut;
    ah = a[SYM_W-1:HALF_W];
    al = a[HALF_W-1:0];
    bh = b[SYM_W-1:HALF_W];
    bl = b[HALF_W-1:0];
    lowProd = gf64Mul(al, bl);
    hiOut = gf64Mul(ah ^ al, bh ^ bl) ^ lowProd;
    loOut = gf64Mul(gf64Mul(ah, bh), EXT_CONST) ^ lowProd;
    return {hiOut, loOut};
  endfunction

  function automatic logic [SYM_W-1:0] gfPow(input logic [SYM_W-1:0] base, input int expo);
    logic [SYM_W-1:0] r;
    r = {{(SYM_W-1){1'b0}}, 1'b1};
    for (int i = 0; i < expo; i++) r = gf4096Mul(r, base);
    return r;
  endfunction

endpackage

// File: rtl/gf4096_mul.sv
module gf4096_mul
  import rs_syn_pkg::*;
(
  input  logic [SYM_W-1:0] opA,
  input  logic [SYM_W-1:0] opB,
  output logic [SYM_W-1:0] prod
);

  logic [HALF_W-1:0] aHi, aLo, bHi, bLo;
  logic [HALF_W-1:0] crossProd, lowProd, highProd, highScaled;

  assign aHi = opA[SYM_W-1:HALF_W];
  assign aLo = opA[HALF_W-1:0];
  assign bHi = opB[SYM_W-1:HALF_W];
  assign bLo = opB[HALF_W-1:0];

  always_comb begin
    crossProd  = gf64Mul(aHi ^ aLo, bHi ^ bLo);
    lowProd    = gf64Mul(aLo, bLo);
    highProd   = gf64Mul(aHi, bHi);
    highScaled = gf64Mul(highProd, EXT_CONST);
    prod       = {crossProd ^ lowProd, highScaled ^ lowProd};
  end

endmodule

// File: rtl/rs_syn_ctrl.sv
module rs_syn_ctrl
  import rs_syn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inStart,
  input  logic        inLast,
  output ctrlStrobe_t strobe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WANT_HOLD,
    ST_WANT_SPLIT,
    ST_WANT_JOIN,
    ST_FLUSH
  } packState_e;

  packState_e state, nextState;

  always_comb begin
    strobe = '0;
    strobe.sel = SEL_HEAD;
    nextState = state;
    if (state == ST_FLUSH) begin
      strobe.absorb = 1'b1;
      strobe.sel = SEL_TAIL_NIB;
      strobe.finish = 1'b1;
      nextState = ST_IDLE;
    end else if (inValid && inStart) begin
      strobe.absorb = 1'b1;
      strobe.clearAcc = 1'b1;
      strobe.sel = SEL_HEAD;
      strobe.finish = inLast;
      nextState = inLast ? ST_IDLE : ST_WANT_HOLD;
    end else if (inValid) begin
      unique case (state)
        ST_WANT_HOLD: begin
          if (inLast) begin
            strobe.absorb = 1'b1;
            strobe.sel = SEL_TAIL_BYTE;
            strobe.finish = 1'b1;
            nextState = ST_IDLE;
          end else begin
            strobe.holdByte = 1'b1;
            nextState = ST_WANT_SPLIT;
          end
        end
        ST_WANT_SPLIT: begin
          strobe.absorb = 1'b1;
          strobe.sel = SEL_SPLIT;
          strobe.holdNib = 1'b1;
          nextState = inLast ? ST_FLUSH : ST_WANT_JOIN;
        end
        ST_WANT_JOIN: begin
          strobe.absorb = 1'b1;
          strobe.sel = SEL_JOIN;
          strobe.finish = inLast;
          nextState = inLast ? ST_IDLE : ST_WANT_HOLD;
        end
        default: nextState = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/rs_syn_datapath.sv
module rs_syn_datapath
  import rs_syn_pkg::*;
#(
  parameter int NUM_SYN = 8,
  parameter int FIRST_ROOT = 0,
  localparam int NUM_WORDS = NUM_SYN / 2,
  localparam int OUT_W = NUM_WORDS * 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BYTE_W-1:0]  inByte,
  input  ctrlStrobe_t        strobe,
  output logic [OUT_W-1:0]   synWords,
  output logic               errFlag,
  output logic               resValid
);

  localparam int PAD_W = 16 - SYM_W;

  logic [BYTE_W-1:0] heldByte;
  logic [NIB_W-1:0] heldNib;
  logic [SYM_W-1:0] symbol;
  logic [NUM_SYN-1:0][SYM_W-1:0] acc;
  logic [NUM_SYN-1:0][SYM_W-1:0] scaled;
  logic finishQ;

  always_comb begin
    unique case (strobe.sel)
      SEL_HEAD:      symbol = {{NIB_W{1'b0}}, inByte};
      SEL_SPLIT:     symbol = {heldByte, inByte[BYTE_W-1:NIB_W]};
      SEL_JOIN:      symbol = {heldNib, inByte};
      SEL_TAIL_BYTE: symbol = {inByte, {NIB_W{1'b0}}};
      SEL_TAIL_NIB:  symbol = {heldNib, {BYTE_W{1'b0}}};
      default:       symbol = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldByte <= '0;
      heldNib <= '0;
    end else begin
      if (strobe.holdByte) heldByte <= inByte;
      if (strobe.holdNib)  heldNib <= inByte[NIB_W-1:0];
    end
  end

  for (genvar j = 0; j < NUM_SYN; j++) begin : g_lane
    localparam logic [SYM_W-1:0] ROOT = gfPow(PRIM_ELEM, FIRST_ROOT + j);
    gf4096_mul u_mul (
      .opA (acc[j]),
      .opB (ROOT),
      .prod(scaled[j])
    );
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               acc[j] <= '0;
      else if (strobe.absorb)  acc[j] <= strobe.clearAcc ? symbol : (scaled[j] ^ symbol);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      finishQ <= 1'b0;
      resValid <= 1'b0;
      errFlag <= 1'b0;
    end else begin
      finishQ <= strobe.finish;
      if (strobe.clearAcc) begin
        resValid <= 1'b0;
        errFlag <= 1'b0;
      end else if (finishQ) begin
        resValid <= 1'b1;
        errFlag <= |acc;
      end
    end
  end

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_word
    assign synWords[32*k +: 32] = {{PAD_W{1'b0}}, acc[2*k+1], {PAD_W{1'b0}}, acc[2*k]};
  end

endmodule

// File: rtl/rs_syndrome_gen.sv
module rs_syndrome_gen
  import rs_syn_pkg::*;
#(
  parameter int NUM_SYN = 8,
  parameter int FIRST_ROOT = 0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inStart,
  input  logic                  inLast,
  input  logic [7:0]            inByte,
  output logic [NUM_SYN*16-1:0] synWords,
  output logic                  errFlag,
  output logic                  resValid
);

  ctrlStrobe_t strobe;

  rs_syn_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inStart(inStart),
    .inLast (inLast),
    .strobe (strobe)
  );

  rs_syn_datapath #(
    .NUM_SYN   (NUM_SYN),
    .FIRST_ROOT(FIRST_ROOT)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .strobe  (strobe),
    .synWords(synWords),
    .errFlag (errFlag),
    .resValid(resValid)
  );

endmodule

// File: rtl/rs_syn_checker.sv
module rs_syn_checker #(
  parameter int NUM_SYN = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  inValid,
  input logic                  inStart,
  input logic                  inLast,
  input logic [NUM_SYN*16-1:0] synWords,
  input logic                  errFlag,
  input logic                  resValid
);

  // R8: a frame start withdraws the previous result
  a_r8_start_clears_valid: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStart) |=> !resValid);

  // R6: the flag is only raised together with valid results
  a_r6_flag_qualified: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> resValid);

  // R6: with valid results the flag reflects the presented syndromes
  a_r6_flag_matches: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> (errFlag == (synWords != '0)));

  // R9: held results do not move until a new frame starts
  a_r9_hold_results: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !(inValid && inStart)) |=> $stable(synWords) && $stable(errFlag));

  // R7: a one-byte frame reports one edge after its only symbol is absorbed
  a_r7_single_latency: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inStart && inLast) ##1 !(inValid && inStart) |=> resValid);

endmodule

bind rs_syndrome_gen rs_syn_checker #(.NUM_SYN(NUM_SYN)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inStart (inStart),
  .inLast  (inLast),
  .synWords(synWords),
  .errFlag (errFlag),
  .resValid(resValid)
);

// File: tb/tb_rs_syndrome_gen.sv
module tb_rs_syndrome_gen;

  localparam int NSYN = 8;
  localparam int OUTW = NSYN * 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inStart = 1'b0;
  logic inLast = 1'b0;
  logic [7:0] inByte = '0;
  logic [OUTW-1:0] synWords;
  logic errFlag;
  logic resValid;

  rs_syndrome_gen #(.NUM_SYN(NSYN)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inStart(inStart), .inLast(inLast),
    .inByte(inByte), .synWords(synWords), .errFlag(errFlag), .resValid(resValid)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [OUTW-1:0] words;
    logic flag;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [7:0] frame[$];
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // independent field model: full carry-less product then reduction
  function automatic logic [5:0] m64(input logic [5:0] a, input logic [5:0] b);
    logic [10:0] p;
    p = '0;
    for (int i = 0; i < 6; i++) if (b[i]) p = p ^ (11'(a) << i);
    for (int k = 10; k >= 6; k--) if (p[k]) p = p ^ (11'h43 << (k - 6));
    return p[5:0];
  endfunction

  function automatic logic [11:0] m4096(input logic [11:0] a, input logic [11:0] b);
    logic [5:0] ll;
    ll = m64(a[5:0], b[5:0]);
    return {m64(a[11:6] ^ a[5:0], b[11:6] ^ b[5:0]) ^ ll,
            m64(m64(a[11:6], b[11:6]), 6'h21) ^ ll};
  endfunction

  function automatic expItem_t model(input string tag);
    expItem_t it;
    int n, nbits, nsym;
    logic [11:0] syms[$];
    logic [11:0] root, pw, s;
    n = frame.size();
    nbits = 4 + 8 * n;
    nsym = (nbits + 11) / 12;
    for (int sIdx = 0; sIdx < nsym; sIdx++) begin
      logic [11:0] v;
      v = '0;
      for (int b = 0; b < 12; b++) begin
        int g;
        logic bitv;
        g = sIdx * 12 + b;
        if (g < 4 || g >= nbits) bitv = 1'b0;
        else bitv = frame[(g - 4) / 8][7 - ((g - 4) % 8)];
        v = {v[10:0], bitv};
      end
      syms.push_back(v);
    end
    it.words = '0;
    root = 12'h001;
    for (int j = 0; j < NSYN; j++) begin
      s = '0;
      pw = 12'h001;
      for (int i = nsym - 1; i >= 0; i--) begin
        s = s ^ m4096(syms[i], pw);
        pw = m4096(pw, root);
      end
      it.words[32 * (j / 2) + 16 * (j % 2) +: 12] = s;
      root = m4096(root, 12'hE01);
    end
    it.flag = (it.words != '0);
    it.tag = tag;
    return it;
  endfunction

  task automatic check(input bit ok, input string what, input logic [OUTW-1:0] act,
                       input logic [OUTW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // mode 0: pseudo-random, 1: zeros, 2: counting
  task automatic fillFrame(input int n, input int mode, input int seed);
    logic [7:0] x;
    frame.delete();
    x = 8'(seed);
    for (int i = 0; i < n; i++) begin
      if (mode == 1) frame.push_back(8'h00);
      else if (mode == 2) frame.push_back(8'(i + seed));
      else begin
        x = {x[6:0], x[7] ^ x[5] ^ x[4] ^ x[3]} ^ 8'h5A;
        frame.push_back(x);
      end
    end
  endtask

  task automatic sendFrame(input int n, input int mode, input int seed, input string tag,
                           input bit latCheck);
    fillFrame(n, mode, seed);
    expQ.push_back(model(tag));
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inStart = (i == 0);
      inLast = (i == n - 1);
      inByte = frame[i];
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0; inLast = 1'b0;
    if (latCheck) begin
      // R7: not yet valid just after the edge accepting the last byte
      check(resValid == 1'b0, "R7 valid too early", OUTW'(resValid), '0);
      if (n % 3 == 0) begin
        @(negedge clk);
        check(resValid == 1'b0, "R7 valid before trailing nibble", OUTW'(resValid), '0);
      end
      @(negedge clk);
      check(resValid == 1'b1, "R7 valid missing", OUTW'(resValid), OUTW'(1));
    end else begin
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  logic prevValid = 1'b0;
  always @(negedge clk) begin
    if (rstN && resValid && !prevValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R8 unexpected result", synWords, '0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        for (int k = 0; k < NSYN / 2; k++)
          check(synWords[32*k +: 32] == e.words[32*k +: 32],
                $sformatf("%s R4 R5 word %0d", e.tag, k),
                OUTW'(synWords[32*k +: 32]), OUTW'(e.words[32*k +: 32]));
        check(errFlag == e.flag, $sformatf("%s R6 flag", e.tag), OUTW'(errFlag), OUTW'(e.flag));
      end
    end
    prevValid <= resValid;
  end

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [OUTW-1:0] snap;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(resValid == 1'b0 && errFlag == 1'b0, "R10 status after reset",
          OUTW'({resValid, errFlag}), '0);
    check(synWords == '0, "R10 syndromes after reset", synWords, '0);
    rstN = 1'b1;
    @(negedge clk);

    sendFrame(1, 2, 8'hA5, "R2 single byte", 1'b1);   // R2 head symbol only
    sendFrame(6, 1, 0, "R6 zero frame", 1'b1);         // R6 flag clear
    sendFrame(4, 0, 3, "R2 ends on join", 1'b1);       // R2
    sendFrame(2, 0, 7, "R3 tail byte", 1'b1);          // R3 trailing byte padded
    sendFrame(3, 0, 11, "R3 tail nibble", 1'b1);       // R3 trailing nibble flush
    sendFrame(9, 2, 1, "R1 counting", 1'b0);           // R1 exercised through syndromes
    sendFrame(14, 0, 99, "R4 check bytes", 1'b0);      // R4

    // R9: stray bytes outside a frame are ignored
    snap = synWords;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      inValid = 1'b1; inStart = 1'b0; inLast = (i == 2); inByte = 8'(8'h3C + i);
    end
    @(negedge clk);
    inValid = 1'b0; inLast = 1'b0;
    repeat (2) @(negedge clk);
    check(synWords == snap, "R9 syndromes disturbed", synWords, snap);
    check(resValid == 1'b1, "R9 valid dropped", OUTW'(resValid), OUTW'(1));

    // R8: abandoned frame, then a new start overrides it
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      inValid = 1'b1; inStart = (i == 0); inLast = 1'b0; inByte = 8'(8'hE7 ^ i);
    end
    @(negedge clk);
    inValid = 1'b0; inStart = 1'b0;
    check(resValid == 1'b0, "R8 valid not cleared by start", OUTW'(resValid), '0);
    sendFrame(7, 0, 42, "R8 restart", 1'b1);

    // R3: full page 2048 + 14 bytes -> 1375 symbols
    sendFrame(2062, 0, 17, "R3 full page", 1'b1);

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R7 results missing", OUTW'(expQ.size()), '0);
    // R11: starts kept at least two idle cycles after last throughout
    finishRun();
  end

endmodule